// File: doc/BRIEF.md
# Asynchronous Bus Read Master

This block runs read cycles on an external bus where the address and the 16-bit data path are separate, and the slave ends each cycle with an acknowledge that is not aligned to the local clock. A client hands over a byte address and a transfer size (byte, word or long word) through a valid/ready request port. The block places the word address on the bus one clock early. It then asserts the address strobe together with the upper and/or lower data strobe, and waits for the slave's acknowledge. It latches the data, and returns the result right-aligned on a response port with a one-cycle valid pulse.

Byte reads use the internal address bit 0 to choose a lane. An even address selects the upper strobe and bits 15..8, and an odd address selects the lower strobe and bits 7..0. The chosen byte always comes back in bits 7..0 of the result. Long-word reads are split into two word cycles at the address and at the address plus 2. A word or long-word request at an odd address is refused with an error response, and no bus activity takes place.

The request side follows valid/ready rules. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from acceptance until the response has been given and the slave has released its acknowledge, so a client holding `req_valid` simply waits. The response port has no back-pressure: `rsp_valid` is a single-cycle pulse that the client must take when it comes.

Top module: `bus_rd_master`

## Requirements
- R1: After reset, `bus_as_n`, `bus_uds_n` and `bus_lds_n` are high (negated), `rsp_valid` is low and `req_ready` is high.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low from acceptance until the response has been given.
- R3: `bus_addr` carries byte-address bits AW-1..1 of the request, so `bus_addr == req_addr >> 1`. Address bit 0 is never driven outward.
- R4: `bus_addr` is stable in the clock before `bus_as_n` falls and in the clock where it rises again. The data strobes fall in the same cycle as `bus_as_n` and are all high when it rises. `bus_rw` reads 1 (read) throughout.
- R5: A word read (`req_size` 2'b01, or 2'b11, which is treated as a word) asserts both data strobes at once and returns `{16'h0, D15..D0}`.
- R6: A byte read (`req_size` 2'b00) asserts exactly one strobe. Address bit 0 = 0 asserts only `bus_uds_n` and returns `{24'h0, D15..D8}`. Bit 0 = 1 asserts only `bus_lds_n` and returns `{24'h0, D7..D0}`.
- R7: A long read (`req_size` 2'b10) runs two word cycles, to word address A and then A+1. The first word lands in `rsp_data[31:16]` and the second in `rsp_data[15:0]`.
- R8: `bus_dtack_n` passes through a two-flop synchronizer. For a byte or word read, `rsp_valid` rises 4+N clock edges after the accepting edge, where N is the number of clocks the slave delays its acknowledge after seeing the strobes.
- R9: A new bus cycle (`bus_as_n` falling) never starts while the slave still holds `bus_dtack_n` low from the previous cycle.
- R10: A word or long request with address bit 0 = 1 produces `rsp_valid` with `rsp_err` = 1 and `rsp_data` = 0 one edge after acceptance, and no strobe is asserted.
- R11: Each accepted request gives exactly one `rsp_valid` pulse of one cycle. `rsp_err` is 0 for reads that complete on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW (24) | Byte address of the read |
| req_size | input | 2 | 00 byte, 01 word, 10 long, 11 word |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | 2*DW (32) | Right-aligned result |
| rsp_err | output | 1 | Misaligned request refused |
| bus_addr | output | AW-1 (23) | Word address, byte-address bits AW-1..1 |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rw | output | 1 | Read/write direction, 1 = read |
| bus_uds_n | output | 1 | Upper data strobe (D15..D8), active low |
| bus_lds_n | output | 1 | Lower data strobe (D7..D0), active low |
| bus_dtack_n | input | 1 | Slave acknowledge, asynchronous, active low |
| bus_data | input | DW (16) | Read data bus |

## Verification
For a byte or word read the response is due 4+N edges after the accepting edge. One edge goes to address setup and one to the strobes, the two synchronizer flops take two more, and N comes from the slave's delay. A misaligned request answers on the very next edge. The bench samples on falling edges and counts falling edges from the one that follows the accepting edge, so it expects `rsp_valid` exactly at count 4+N, or 0 for a refused request. It then requires the pulse to be gone one sample later. Bus-side timing (address setup and hold, release of the acknowledge before a new cycle) is observed by a reactive slave model at the cycle's start and end samples. That model delays its acknowledge and release by programmable numbers of clocks.

// File: rtl/brm_pkg.sv
package brm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_RELEASE
  } seq_state_e;

  function automatic logic size_is_byte(input logic [1:0] sz);
    return sz == SZ_BYTE;
  endfunction

  function automatic logic size_is_long(input logic [1:0] sz);
    return sz == SZ_LONG;
  endfunction

endpackage

// File: rtl/brm_sync.sv
module brm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_in};
      end
    end
  endgenerate

  assign q_out = chain[STAGES-1];

endmodule

// File: rtl/brm_seq.sv
module brm_seq
  import brm_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          ack_s,
  output logic [AW-2:0] bus_addr,
  output logic          bus_as_n,
  output logic          bus_rw,
  output logic          bus_uds_n,
  output logic          bus_lds_n,
  output logic          cap_en,
  output logic          cap_byte,
  output logic          cap_lane,
  output logic          cap_hi,
  output logic          clr_res,
  output logic          rsp_valid,
  output logic          rsp_err
);

  localparam int WAW = AW - 1;

  seq_state_e     st_q;
  logic [WAW-1:0] wadr_q;
  logic [1:0]     size_q;
  logic           lane_q;
  logic           second_q;
  logic           rsp_v_q, rsp_e_q;
  logic           as_q, uds_q, lds_q;

  logic req_fire, misalign, last_word;

  assign req_ready = (st_q == ST_IDLE) && !rsp_v_q;
  assign req_fire  = req_valid && req_ready;
  assign misalign  = !size_is_byte(req_size) && req_addr[0];
  assign last_word = !size_is_long(size_q) || second_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wadr_q   <= '0;
      size_q   <= SZ_BYTE;
      lane_q   <= 1'b0;
      second_q <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_e_q  <= 1'b0;
      as_q     <= 1'b1;
      uds_q    <= 1'b1;
      lds_q    <= 1'b1;
    end else begin
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_fire) begin
            if (misalign) begin
              rsp_v_q <= 1'b1;
              rsp_e_q <= 1'b1;
            end else begin
              wadr_q   <= req_addr[AW-1:1];
              size_q   <= req_size;
              lane_q   <= req_addr[0];
              second_q <= 1'b0;
              st_q     <= ST_SETUP;
            end
          end
        end
        ST_SETUP: begin
          as_q  <= 1'b0;
          uds_q <= size_is_byte(size_q) && lane_q;
          lds_q <= size_is_byte(size_q) && !lane_q;
          st_q  <= ST_STROBE;
        end
        ST_STROBE: begin
          if (ack_s) begin
            as_q  <= 1'b1;
            uds_q <= 1'b1;
            lds_q <= 1'b1;
            st_q  <= ST_HOLD;
            if (last_word) rsp_v_q <= 1'b1;
          end
        end
        ST_HOLD: begin
          st_q <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (!ack_s) begin
            if (!last_word) begin
              second_q <= 1'b1;
              wadr_q   <= wadr_q + 1'b1;
              st_q     <= ST_SETUP;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cap_en    = (st_q == ST_STROBE) && ack_s;
  assign cap_byte  = size_is_byte(size_q);
  assign cap_lane  = lane_q;
  assign cap_hi    = size_is_long(size_q) && !second_q;
  assign clr_res   = req_fire;
  assign rsp_valid = rsp_v_q;
  assign rsp_err   = rsp_e_q;
  assign bus_addr  = wadr_q;
  assign bus_as_n  = as_q;
  assign bus_uds_n = uds_q;
  assign bus_lds_n = lds_q;
  assign bus_rw    = 1'b1;

endmodule

// File: rtl/brm_pack.sv
module brm_pack #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            cap_en,
  input  logic            cap_byte,
  input  logic            cap_lane,
  input  logic            cap_hi,
  input  logic [DW-1:0]   bus_data,
  output logic [2*DW-1:0] result
);

  localparam int BW = DW / 2;
  localparam int RW = 2 * DW;

  logic [RW-1:0] res_q;
  logic [BW-1:0] lane_byte;

  assign lane_byte = cap_lane ? bus_data[BW-1:0] : bus_data[DW-1:BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (clr) begin
      res_q <= '0;
    end else if (cap_en) begin
      if (cap_byte)    res_q <= {{(RW-BW){1'b0}}, lane_byte};
      else if (cap_hi) res_q[RW-1:DW] <= bus_data;
      else             res_q[DW-1:0]  <= bus_data;
    end
  end

  assign result = res_q;

endmodule

// File: rtl/bus_rd_master.sv
module bus_rd_master #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_size,
  output logic            rsp_valid,
  output logic [2*DW-1:0] rsp_data,
  output logic            rsp_err,
  output logic [AW-2:0]   bus_addr,
  output logic            bus_as_n,
  output logic            bus_rw,
  output logic            bus_uds_n,
  output logic            bus_lds_n,
  input  logic            bus_dtack_n,
  input  logic [DW-1:0]   bus_data
);

  logic ack_n_s, ack_s;
  logic cap_en, cap_byte, cap_lane, cap_hi, clr_res;

  brm_sync #(.STAGES(2), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(bus_dtack_n), .q_out(ack_n_s)
  );

  assign ack_s = !ack_n_s;

  brm_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .ack_s(ack_s),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rw(bus_rw),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .cap_en(cap_en), .cap_byte(cap_byte), .cap_lane(cap_lane), .cap_hi(cap_hi),
    .clr_res(clr_res), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
  );

  brm_pack #(.DW(DW)) pack_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_res), .cap_en(cap_en),
    .cap_byte(cap_byte), .cap_lane(cap_lane), .cap_hi(cap_hi),
    .bus_data(bus_data), .result(rsp_data)
  );

endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [AW-2:0] bus_addr,
  input logic          bus_as_n,
  input logic          bus_uds_n,
  input logic          bus_lds_n,
  input logic          ack_s
);

  // R4: address settled one clock before the cycle opens
  a_r4_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> $stable(bus_addr));

  // R4: address held in the clock the cycle closes
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> $stable(bus_addr));

  // R4: data strobes open only together with the address strobe
  a_r4_strobe_with_as: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_uds_n) || $fell(bus_lds_n)) |-> $fell(bus_as_n));

  // R4: all strobes negated together
  a_r4_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_as_n) |-> (bus_uds_n && bus_lds_n));

  // R6: an open cycle always has at least one data strobe
  a_r6_strobe_present: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !(bus_uds_n && bus_lds_n));

  // R9: no cycle opens while the synchronized acknowledge is still asserted
  a_r9_ack_idle_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_as_n) |-> !ack_s);

  // R10: an error response never coincides with bus activity
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> bus_as_n);

  // R11: response is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R2: no new request taken while a bus cycle is open
  a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_as_n |-> !req_ready);

endmodule

bind bus_rd_master brm_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .bus_addr(bus_addr), .bus_as_n(bus_as_n),
  .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .ack_s(ack_s)
);

// File: tb/bus_rd_master_tb_top.sv
`timescale 1ns/1ps
module bus_rd_master_tb_top;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b00;
  logic          rsp_valid;
  logic [31:0]   rsp_data;
  logic          rsp_err;
  logic [AW-2:0] bus_addr;
  logic          bus_as_n, bus_rw, bus_uds_n, bus_lds_n;
  logic          dtack_n = 1'b1;
  logic [DW-1:0] bdata = 16'h0;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  // slave model configuration and log
  int wait_n = 0;
  int rel_hold = 0;
  int ncyc = 0;
  int viol_r9 = 0;
  int viol_r4 = 0;
  logic [AW-2:0] log_addr [0:7];
  logic          log_uds  [0:7];
  logic          log_lds  [0:7];
  logic          log_rw   [0:7];

  always #5 clk = ~clk;

  bus_rd_master #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rw(bus_rw),
    .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n),
    .bus_dtack_n(dtack_n), .bus_data(bdata)
  );

  function automatic logic [15:0] word_at(input logic [AW-2:0] wa);
    return wa[15:0] * 16'h1357 + 16'h2468;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reactive slave, samples and drives on falling edges
  initial begin
    logic prev_as;
    logic [AW-2:0] prev_addr, cur_addr;
    int wcnt, rcnt;
    prev_as = 1'b1; prev_addr = '0; cur_addr = '0; wcnt = 0; rcnt = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (!bus_as_n && prev_as) begin
          if (!dtack_n) viol_r9++;
          if (bus_addr !== prev_addr) viol_r4++;
          if (ncyc < 8) begin
            log_addr[ncyc] = bus_addr;
            log_uds[ncyc]  = bus_uds_n;
            log_lds[ncyc]  = bus_lds_n;
            log_rw[ncyc]   = bus_rw;
          end
          ncyc++;
          cur_addr = bus_addr;
          wcnt = 0;
        end
        if (!bus_as_n && dtack_n) begin
          if (wcnt >= wait_n) begin
            bdata = word_at(bus_addr);
            dtack_n = 1'b0;
          end else wcnt++;
        end
        if (bus_as_n && !prev_as) begin
          if (bus_addr !== cur_addr) viol_r4++;
          rcnt = 0;
        end
        if (bus_as_n && !dtack_n) begin
          if (rcnt >= rel_hold) begin
            dtack_n = 1'b1;
            bdata = 16'hDEAD;
          end else rcnt++;
        end
        prev_as = bus_as_n;
        prev_addr = bus_addr;
      end
    end
  end

  // issue one request, return result, error flag and latency
  task automatic do_req(input logic [AW-1:0] a, input logic [1:0] sz,
                        output logic [31:0] d, output logic e, output int lat,
                        output bit ready_in_flight, output bit pulse_ok);
    int guard;
    @(negedge clk);
    guard = 0;
    while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    ncyc = 0; viol_r9 = 0; viol_r4 = 0;
    req_valid = 1'b1; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; ready_in_flight = 0;
    while (!rsp_valid && lat < 300) begin
      if (req_ready) ready_in_flight = 1;
      @(negedge clk);
      lat++;
    end
    d = rsp_data; e = rsp_err;
    @(negedge clk);
    pulse_ok = !rsp_valid;
    guard = 0;
    while ((!req_ready || !dtack_n) && guard < 500) begin @(negedge clk); guard++; end
  endtask

  task automatic t_reset();
    chk(bus_as_n === 1'b1, "R1", "as_n after reset", 32'(bus_as_n), 32'h1);
    chk(bus_uds_n === 1'b1 && bus_lds_n === 1'b1, "R1", "data strobes after reset",
        {30'h0, bus_uds_n, bus_lds_n}, 32'h3);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(req_ready === 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);
  endtask

  task automatic t_word(input logic [AW-1:0] a, input int wn, input logic [1:0] sz);
    logic [31:0] d; logic e; int lat; bit rdy, pok;
    logic [15:0] w;
    wait_n = wn; rel_hold = 0;
    do_req(a, sz, d, e, lat, rdy, pok);
    w = word_at(a[AW-1:1]);
    chk(d === {16'h0, w}, "R5", "word data", d, {16'h0, w});
    chk(ncyc == 1 && log_uds[0] === 1'b0 && log_lds[0] === 1'b0, "R5",
        "both strobes once", {ncyc[29:0], log_uds[0], log_lds[0]}, 32'h4);
    chk(log_addr[0] === a[AW-1:1], "R3", "bus address", 32'(log_addr[0]), 32'(a[AW-1:1]));
    chk(log_rw[0] === 1'b1, "R4", "rw reads", 32'(log_rw[0]), 32'h1);
    chk(viol_r4 == 0, "R4", "address setup/hold", 32'(viol_r4), 32'h0);
    chk(lat == 4 + wn, "R8", "word latency", 32'(lat), 32'(4 + wn));
    chk(e === 1'b0, "R11", "no error", 32'(e), 32'h0);
    chk(pok, "R11", "single pulse", 32'(pok), 32'h1);
    chk(!rdy, "R2", "ready low in flight", 32'(rdy), 32'h0);
  endtask

  task automatic t_byte(input logic [AW-1:0] a, input int wn);
    logic [31:0] d; logic e; int lat; bit rdy, pok;
    logic [15:0] w; logic [31:0] exp;
    wait_n = wn; rel_hold = 0;
    do_req(a, 2'b00, d, e, lat, rdy, pok);
    w = word_at(a[AW-1:1]);
    exp = a[0] ? {24'h0, w[7:0]} : {24'h0, w[15:8]};
    chk(d === exp, "R6", "byte data right-aligned", d, exp);
    chk(ncyc == 1 && log_uds[0] === a[0] && log_lds[0] === !a[0], "R6",
        "single lane strobe", {ncyc[29:0], log_uds[0], log_lds[0]},
        {30'h1, a[0], !a[0]});
    chk(lat == 4 + wn, "R8", "byte latency", 32'(lat), 32'(4 + wn));
    chk(log_addr[0] === a[AW-1:1], "R3", "byte bus address", 32'(log_addr[0]),
        32'(a[AW-1:1]));
  endtask

  task automatic t_long(input logic [AW-1:0] a, input int rh);
    logic [31:0] d; logic e; int lat; bit rdy, pok;
    logic [AW-2:0] wa; logic [31:0] exp;
    wait_n = 1; rel_hold = rh;
    do_req(a, 2'b10, d, e, lat, rdy, pok);
    wa = a[AW-1:1];
    exp = {word_at(wa), word_at(wa + 1'b1)};
    chk(d === exp, "R7", "long data order", d, exp);
    chk(ncyc == 2, "R7", "two bus cycles", 32'(ncyc), 32'h2);
    chk(log_addr[0] === wa && log_addr[1] === wa + 1'b1, "R7", "second address +2",
        32'(log_addr[1]), 32'(wa + 1'b1));
    chk(viol_r9 == 0, "R9", "no start while ack held", 32'(viol_r9), 32'h0);
    chk(viol_r4 == 0, "R4", "long address setup/hold", 32'(viol_r4), 32'h0);
    chk(pok && e === 1'b0, "R11", "long single pulse", {30'h0, pok, e}, 32'h2);
  endtask

  task automatic t_misalign(input logic [1:0] sz);
    logic [31:0] d; logic e; int lat; bit rdy, pok;
    wait_n = 0; rel_hold = 0;
    do_req(24'h001235, sz, d, e, lat, rdy, pok);
    repeat (8) @(negedge clk);
    chk(e === 1'b1 && lat == 0, "R10", "error response next edge",
        {lat[30:0], e}, 32'h1);
    chk(d === 32'h0, "R10", "error data zero", d, 32'h0);
    chk(ncyc == 0, "R10", "no bus cycle", 32'(ncyc), 32'h0);
    chk(pok, "R11", "error single pulse", 32'(pok), 32'h1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word(24'hABCDE4, 0, 2'b01);
    t_word(24'h13572A, 3, 2'b01);
    t_word(24'h000100, 1, 2'b11);
    t_byte(24'h246808, 0);
    t_byte(24'h246809, 2);
    t_byte(24'hFFFFFF, 0);
    t_long(24'h0AB0FC, 0);
    t_long(24'h7FFFFE, 5);
    t_misalign(2'b01);
    t_misalign(2'b10);
    // a rejected request must not disturb the next good read
    t_word(24'h000042, 0, 2'b01);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      done_flag = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule